// File: doc/BRIEF.md
# I2C Serial EEPROM Target with Upper-Half Write Protection

This block is an I2C target that behaves as a 256-byte serial EEPROM. It runs on a fast system clock and oversamples the bus. SCL and SDA each pass through a sampled-input glitch filter before edge detection. START and STOP conditions are recognised at any point. The target answers a device-select byte, takes a one-byte word address, and then either receives data bytes or returns data. Only one byte addresses the target: the fixed type nibble `1010`, then the three strap inputs, then the read/write bit.

Incoming data bytes collect in a 16-entry page buffer, and the buffer marks each entry it has filled. A STOP commits the filled entries to the storage array in one clock and starts a write-cycle timer. While that timer runs, the target does not acknowledge any device-select byte. A write-protect input turns away data aimed at word addresses 0x80 to 0xFF. That data is still acknowledged on the bus, but it never reaches the buffer.

The control state machine has these states:
- `S_IDLE`: the bus is free.
- `S_DEV`: a device-select byte is shifting in.
- `S_DACK`: the target acknowledges the device-select byte.
- `S_WADR`: the word address is shifting in.
- `S_AACK`: the target acknowledges the word address.
- `S_WDAT`: a data byte is shifting in.
- `S_WACK`: the target acknowledges the data byte.
- `S_RD`: the target drives a data byte.
- `S_RACK`: the target samples the controller's acknowledge.
- `S_WAIT`: the target ignores the bus until the next START or STOP.

The transitions are:
- A START from any state goes to `S_DEV`, and a STOP from any state goes to `S_IDLE`.
- `S_DEV` goes to `S_DACK` after eight bits if the select byte matches and no write cycle is running. Otherwise it goes to `S_WAIT`.
- `S_DACK` goes to `S_RD` or to `S_WADR`, according to the read/write bit.
- `S_WADR` goes to `S_AACK`, which goes to `S_WDAT`.
- `S_WDAT` and `S_WACK` alternate for as long as the controller sends data.
- `S_RD` goes to `S_RACK` after eight bits.
- `S_RACK` goes back to `S_RD` on an acknowledge, or to `S_WAIT` on a not-acknowledge.

Top module: `eeprom_i2c_target`

## Requirements
- R1: After reset, SDA is released, every array byte reads 0xFF, the address pointer is 0x00 and no write cycle is running.
- R2: The target acknowledges a device-select byte only when its upper seven bits equal `1010` followed by `dev_sel[2:0]`. Any other select byte gets no acknowledge, and the target then ignores the bus until the next START or STOP.
- R3: A byte written at a word address reads back at that address through a random read. A random read is a write of the word address, then a repeated START, then a read-mode select byte.
- R4: During a write, the pointer's low four bits advance after each data byte and wrap inside the 16-byte page. The upper four bits stay fixed. A byte that arrives after 16 others replaces the earlier byte at the same page slot.
- R5: A STOP that ends a write with at least one buffered byte commits the buffer and starts a write cycle of `TWR_CYC` clocks. During that cycle no device-select byte is acknowledged. After the cycle, select bytes are acknowledged again.
- R6: While `wr_prot` is high, data bytes aimed at 0x80 to 0xFF are acknowledged but discarded, and they start no write cycle. Addresses 0x00 to 0x7F stay writable.
- R7: A current-address read returns the byte at the pointer. The pointer is one past the last byte read, or the next in-page slot after the last byte written.
- R8: A sequential read returns consecutive bytes. The address goes up by one after each byte and wraps from 0xFF to 0x00. The read ends on a not-acknowledge followed by STOP.
- R9: A pulse shorter than `FILT_CYC` clocks on SCL or SDA has no effect on the received data and raises no START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| dev_sel | input | 3 | Strap value that completes the device-select byte |
| wr_prot | input | 1 | High protects word addresses 0x80 to 0xFF |

## Verification
The bench sets `FILT_CYC` to 3, so a two-clock pulse on SCL or SDA sits just below the rejection threshold and the filter boundary of R9 can be tested. `TWR_CYC` is set to 1000 clocks. That is long enough that a select byte sent straight after a committed write falls inside the busy window. It is also short enough for the bench to wait it out before every readback. With these values the page wrap, the protection split, the pointer wrap at 0xFF and randomised page writes all fit in one short run.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DACK,
        S_WADR,
        S_AACK,
        S_WDAT,
        S_WACK,
        S_RD,
        S_RACK,
        S_WAIT
    } eep_state_t;

endpackage

// File: rtl/eep_deglitch.sv
module eep_deglitch #(
    parameter int FILT_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_flt
);
    localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q   <= 2'b11;
            run_cnt  <= '0;
            line_flt <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_raw};
            if (sync_q[1] == line_flt) begin
                run_cnt <= '0;
            end else if (run_cnt == CW'(FILT_CYC - 1)) begin
                line_flt <= sync_q[1];
                run_cnt  <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // R9: the filtered line only moves to a value the synchronised input held
    a_r9_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_flt) |-> ($past(sync_q[1]) == line_flt));

endmodule

// File: rtl/eep_wtimer.sv
module eep_wtimer #(
    parameter int TWR_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(TWR_CYC + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= CW'(TWR_CYC);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign busy = (left_q != '0);

    // R5: a commit always opens a busy window
    a_r5_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R5: the busy window shrinks by one clock at a time
    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (left_q == $past(left_q) - 1'b1));

endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     buf_we,
    input  logic [PAGE_W-1:0]        buf_idx,
    input  logic [7:0]               buf_din,
    input  logic                     commit,
    input  logic [ADDR_W-PAGE_W-1:0] commit_pg,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    output logic                     pend
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [7:0]            mem  [DEPTH];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pval;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'hFF;
            end
            for (int j = 0; j < PAGE_BYTES; j++) begin
                pbuf[j] <= 8'h00;
            end
            pval <= '0;
        end else begin
            if (commit) begin
                for (int k = 0; k < PAGE_BYTES; k++) begin
                    if (pval[k]) begin
                        mem[{commit_pg, PAGE_W'(k)}] <= pbuf[k];
                    end
                end
            end
            if (clr || commit) begin
                pval <= '0;
            end else if (buf_we) begin
                pbuf[buf_idx] <= buf_din;
                pval[buf_idx] <= 1'b1;
            end
        end
    end

    assign rd_data = mem[rd_addr];
    assign pend    = |pval;

    // R5: a commit empties the page buffer
    a_r5_commit_drains: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !pend);

    // R4: an accepted byte leaves the buffer holding pending data
    a_r4_buffer_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && !clr && !commit) |=> pend);

endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
    import eep_pkg::*;
#(
    parameter int FILT_CYC = 5,
    parameter int TWR_CYC  = 250000,
    parameter int ADDR_W   = 8,
    parameter int PAGE_W   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] dev_sel,
    input  logic       wr_prot
);
    localparam int PG_W = ADDR_W - PAGE_W;

    logic [1:0] raw_in;
    logic [1:0] flt;
    logic       scl_f, sda_f, scl_q, sda_q;
    logic       scl_rise, scl_fall, start_ev, stop_ev;

    eep_state_t        st, st_nx;
    logic [3:0]        bitcnt;
    logic [7:0]        shreg, txreg;
    logic [ADDR_W-1:0] ptr;
    logic              mack;
    logic              busy, dev_hit, byte_done, is_rx, wr_ok;
    logic              buf_we, commit;
    logic [7:0]        rd_data;
    logic              pend;

    // ---------------- input conditioning ----------------
    assign raw_in = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        eep_deglitch #(.FILT_CYC(FILT_CYC)) u_dg (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_raw(raw_in[g]),
            .line_flt(flt[g])
        );
    end

    assign scl_f = flt[1];
    assign sda_f = flt[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise = scl_f & ~scl_q;
    assign scl_fall = ~scl_f & scl_q;
    assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;

    // ---------------- decode helpers ----------------
    assign byte_done = scl_fall && (bitcnt == 4'd8);
    assign dev_hit   = (shreg[7:1] == {DEV_TYPE, dev_sel});
    assign is_rx     = (st == S_DEV) || (st == S_WADR) || (st == S_WDAT);
    assign wr_ok     = !(wr_prot && ptr[ADDR_W-1]);

    // ---------------- next state ----------------
    always_comb begin
        st_nx = st;
        if (stop_ev) begin
            st_nx = S_IDLE;
        end else if (start_ev) begin
            st_nx = S_DEV;
        end else begin
            unique case (st)
                S_IDLE: st_nx = S_IDLE;
                S_WAIT: st_nx = S_WAIT;
                S_DEV:  if (byte_done) st_nx = (dev_hit && !busy) ? S_DACK : S_WAIT;
                S_DACK: if (scl_fall)  st_nx = shreg[0] ? S_RD : S_WADR;
                S_WADR: if (byte_done) st_nx = S_AACK;
                S_AACK: if (scl_fall)  st_nx = S_WDAT;
                S_WDAT: if (byte_done) st_nx = S_WACK;
                S_WACK: if (scl_fall)  st_nx = S_WDAT;
                S_RD:   if (scl_fall && bitcnt == 4'd7) st_nx = S_RACK;
                S_RACK: if (scl_fall)  st_nx = mack ? S_RD : S_WAIT;
                default: st_nx = S_IDLE;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // ---------------- datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            shreg  <= '0;
            txreg  <= 8'hFF;
            ptr    <= '0;
            mack   <= 1'b0;
        end else begin
            if (start_ev || st_nx != st) begin
                bitcnt <= '0;
            end else if ((is_rx && scl_rise) || (st == S_RD && scl_fall)) begin
                bitcnt <= bitcnt + 1'b1;
            end

            if (is_rx && scl_rise) begin
                shreg <= {shreg[6:0], sda_f};
            end

            if (st == S_RACK && scl_rise) begin
                mack <= !sda_f;
            end

            if ((st == S_DACK || st == S_RACK) && st_nx == S_RD) begin
                txreg <= rd_data;
            end else if (st == S_RD && scl_fall) begin
                txreg <= {txreg[6:0], 1'b1};
            end

            if (st == S_WADR && st_nx == S_AACK) begin
                ptr <= shreg[ADDR_W-1:0];
            end else if (st == S_WDAT && st_nx == S_WACK) begin
                ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
            end else if (st == S_RD && st_nx == S_RACK) begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        sda_oe = 1'b0;
        buf_we = 1'b0;
        unique case (st)
            S_DACK, S_AACK, S_WACK: sda_oe = 1'b1;
            S_RD:                   sda_oe = !txreg[7];
            S_WDAT:                 buf_we = (st_nx == S_WACK) && wr_ok;
            default:                sda_oe = 1'b0;
        endcase
    end

    assign commit = stop_ev && pend;

    // ---------------- sub-blocks ----------------
    eep_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_ev),
        .buf_we   (buf_we),
        .buf_idx  (ptr[PAGE_W-1:0]),
        .buf_din  (shreg),
        .commit   (commit),
        .commit_pg(ptr[ADDR_W-1:PAGE_W]),
        .rd_addr  (ptr),
        .rd_data  (rd_data),
        .pend     (pend)
    );

    eep_wtimer #(.TWR_CYC(TWR_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(commit),
        .busy (busy)
    );

    // ---------------- assertions ----------------
    // R1: the bus is never driven while idle
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> !sda_oe);

    // R2: an acknowledge of the select byte follows only a matching byte
    a_r2_ack_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DACK && $past(st) == S_DEV) |->
            ($past(shreg[7:1]) == {DEV_TYPE, $past(dev_sel)}));

    // R5: no select acknowledge while a write cycle runs
    a_r5_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DEV && byte_done && busy && !start_ev && !stop_ev) |=> (st == S_WAIT));

    // R4: data bytes never move the pointer out of its page
    a_r4_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WACK && $past(st) == S_WDAT) |->
            (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

    // R6: a protected byte leaves an empty buffer empty
    a_r6_protected_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WDAT && st_nx == S_WACK && wr_prot && ptr[ADDR_W-1] && !pend) |=> !pend);

    // R8: each byte sent moves the pointer up by one
    a_r8_read_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RACK && $past(st) == S_RD) |-> (ptr == ADDR_W'($past(ptr) + 1'b1)));

    localparam int UNUSED_PG = PG_W;

endmodule

// File: tb/eeprom_i2c_target_bench.sv
module eeprom_i2c_target_bench;

    localparam int CLK_NS = 10;
    localparam int FILT   = 3;
    localparam int TWR    = 1000;
    localparam int H      = 20;
    localparam int Q      = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       wr_prot = 1'b0;
    logic [2:0] dev_sel = 3'b101;
    logic       sda_oe;
    logic       sda_line;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] exp_mem [256];
    logic [7:0] exp_ptr;
    logic [7:0] wdat [32];
    logic       ak;
    logic [7:0] rd;

    assign sda_line = sda_m & ~sda_oe;

    eeprom_i2c_target #(.FILT_CYC(FILT), .TWR_CYC(TWR)) u_eeprom_i2c_target (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .dev_sel(dev_sel),
        .wr_prot(wr_prot)
    );

    always #(CLK_NS / 2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] in_page(input logic [7:0] a, input int k);
        return {a[7:4], a[3:0] + 4'(k)};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); sda_m = 1'b0;
        tick(Q); scl_m = 1'b1;
        tick(H); sda_m = 1'b1;
        tick(H);
    endtask

    task automatic send_bit(input logic b);
        tick(Q); sda_m = b;
        tick(Q); scl_m = 1'b1;
        tick(H); scl_m = 1'b0;
    endtask

    task automatic send_bit_glitch(input logic b);
        tick(3); scl_m = 1'b1;
        tick(FILT - 1); scl_m = 1'b0;
        tick(Q - 3 - (FILT - 1)); sda_m = b;
        tick(Q); scl_m = 1'b1;
        tick(5); sda_m = ~b;
        tick(FILT - 1); sda_m = b;
        tick(H - 5 - (FILT - 1)); scl_m = 1'b0;
    endtask

    task automatic recv_bit(output logic b);
        tick(Q); sda_m = 1'b1;
        tick(Q); scl_m = 1'b1;
        tick(Q); b = sda_line;
        tick(Q); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, input bit glitch, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            if (glitch) send_bit_glitch(d[i]);
            else        send_bit(d[i]);
        end
        recv_bit(b);
        ack = !b;
    endtask

    task automatic recv_byte(output logic [7:0] d);
        logic b;
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            recv_bit(b);
            d = {d[6:0], b};
        end
    endtask

    task automatic do_write(input logic [7:0] a, input int n, input bit glitch, input string tag);
        bus_start();
        send_byte({4'b1010, dev_sel, 1'b0}, 1'b0, ak); chk(tag, int'(ak), 1);
        send_byte(a, 1'b0, ak);                        chk(tag, int'(ak), 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wdat[i], glitch, ak);
            chk(tag, int'(ak), 1);
            if (!(wr_prot && a[7])) exp_mem[in_page(a, i)] = wdat[i];
        end
        bus_stop();
        exp_ptr = in_page(a, n);
    endtask

    task automatic do_read(input bit rand_addr, input logic [7:0] a, input int n, input string tag);
        logic [7:0] p;
        if (rand_addr) begin
            bus_start();
            send_byte({4'b1010, dev_sel, 1'b0}, 1'b0, ak); chk(tag, int'(ak), 1);
            send_byte(a, 1'b0, ak);                        chk(tag, int'(ak), 1);
            p = a;
        end else begin
            p = exp_ptr;
        end
        bus_start();
        send_byte({4'b1010, dev_sel, 1'b1}, 1'b0, ak); chk(tag, int'(ak), 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(rd);
            chk(tag, int'(rd), int'(exp_mem[8'(p + 8'(i))]));
            send_bit(logic'(i == n - 1));
        end
        bus_stop();
        exp_ptr = 8'(p + 8'(n));
    endtask

    task automatic probe(input int expect_ack, input string tag);
        bus_start();
        send_byte({4'b1010, dev_sel, 1'b0}, 1'b0, ak);
        chk(tag, int'(ak), expect_ack);
        bus_stop();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250));
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
        exp_ptr = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: released bus, erased array, pointer at zero
        chk("R1 sda released", int'(sda_oe), 0);
        do_read(1'b0, 8'h00, 1, "R1 erased at pointer 0");

        // R2: wrong select byte is not acknowledged and the rest is ignored
        bus_start();
        send_byte({4'b1010, 3'b110, 1'b0}, 1'b0, ak); chk("R2 mismatch nack", int'(ak), 0);
        send_byte(8'h00, 1'b0, ak);                   chk("R2 ignored after mismatch", int'(ak), 0);
        bus_stop();

        // R3 and R7: byte write, then current-address read, then random read
        wdat[0] = 8'h5A;
        do_write(8'h23, 1, 1'b0, "R3 byte write");
        tick(TWR + 100);
        do_read(1'b0, 8'h00, 1, "R7 current address after write");
        do_read(1'b1, 8'h23, 1, "R3 random read");
        do_read(1'b0, 8'h00, 1, "R7 current address after read");

        // R5: busy after commit, then ready again
        wdat[0] = 8'h11;
        do_write(8'h40, 1, 1'b0, "R5 write");
        probe(0, "R5 nack while busy");
        tick(TWR + 100);
        probe(1, "R5 ack after cycle");
        do_read(1'b1, 8'h40, 1, "R5 committed data");

        // R4: 18 bytes into a page starting at slot 0xC
        for (int i = 0; i < 18; i++) wdat[i] = 8'(8'h30 + i);
        do_write(8'h5C, 18, 1'b0, "R4 page write");
        tick(TWR + 100);
        do_read(1'b1, 8'h50, 16, "R4 page wrap and overwrite");
        do_read(1'b1, 8'h60, 1, "R4 next page untouched");

        // R6: protection of the upper half only
        wr_prot = 1'b1;
        for (int i = 0; i < 4; i++) wdat[i] = 8'(8'hA0 + i);
        do_write(8'h90, 4, 1'b0, "R6 protected bytes acked");
        probe(1, "R6 no write cycle started");
        do_read(1'b1, 8'h90, 4, "R6 protected data unchanged");
        do_write(8'h10, 2, 1'b0, "R6 lower half write");
        tick(TWR + 100);
        do_read(1'b1, 8'h10, 2, "R6 lower half written");
        wr_prot = 1'b0;

        // R8: sequential read across 0xFF to 0x00
        wdat[0] = 8'hAA; wdat[1] = 8'hBB;
        do_write(8'hFE, 2, 1'b0, "R8 setup high");
        tick(TWR + 100);
        wdat[0] = 8'hCC;
        do_write(8'h00, 1, 1'b0, "R8 setup low");
        tick(TWR + 100);
        do_read(1'b1, 8'hFD, 5, "R8 sequential wrap");
        do_read(1'b0, 8'h00, 1, "R8 pointer after wrap");

        // R9: sub-threshold pulses on both lines during a write
        wdat[0] = 8'h6B;
        do_write(8'h33, 1, 1'b1, "R9 glitched write");
        tick(TWR + 100);
        do_read(1'b1, 8'h33, 1, "R9 data intact");

        // Random page writes with random protection, whole page read back
        for (int it = 0; it < 6; it++) begin
            logic [7:0] a;
            int n;
            a = 8'($urandom);
            n = 1 + int'($urandom % 8);
            wr_prot = logic'($urandom % 2);
            for (int i = 0; i < n; i++) wdat[i] = 8'($urandom);
            do_write(a, n, 1'b0, "R4 R6 random write");
            tick(TWR + 100);
            wr_prot = 1'b0;
            do_read(1'b1, {a[7:4], 4'h0}, 16, "R4 R6 random page readback");
        end

        done = 1;
        summary();
        $finish;
    end

endmodule